// File: doc/BRIEF.md
# Typed Shared Set-Associative Cache

This block is a set-associative store in which two kinds of content share the same ways. The two kinds are plain instruction words and reconfiguration context blocks. Each line carries a one-bit kind tag next to its valid bit, address tag and data word. A lookup names both an address and the kind it wants. It hits only on a line whose valid bit is set, whose tag matches and whose kind matches the request.

Lines are replaced through a single-cycle fill strobe. Along with the strobe, an outside allocation unit supplies the kind that should give up a line. The victim is picked inside the addressed set. Empty ways are used first. If there are none, the least recently used line of the requested kind is evicted. If the set holds no line of that kind, the least recently used line overall is evicted instead. Recency is kept as a per-set age ranking, and every hit and every fill refreshes it.

Top module: `typed_shared_cache`

## Requirements
- R1: After a synchronous reset every line is invalid, all lookups miss, and `rsp_valid` and `fill_done` are low in the cycle after reset.
- R2: A lookup accepted at a clock edge gives `rsp_valid` high right after that edge. `rsp_hit` is high if and only if some way holds a valid line with an equal tag and equal kind. On a hit, `rsp_data` carries that line's data; if more than one way matches, the lowest-numbered way wins. On a miss, `rsp_data` is zero.
- R3: A line whose tag matches but whose kind differs from the request (kind 0 = instruction, 1 = context) gives a miss.
- R4: A fill writes the tag, data and kind and sets the valid bit. `fill_done` is high for exactly the cycle after the strobe, and `fill_way` then gives the way number that was written. A lookup of the same address and kind in the next cycle hits.
- R5: If the addressed set has an invalid way, the fill uses the lowest-numbered invalid way, whatever the evict kind is.
- R6: If every way is valid, the fill replaces the least recently used way among the ways whose kind equals `fill_evict_kind`.
- R7: If every way is valid and none of them has the evict kind, the fill replaces the least recently used way of the set.
- R8: A hit and a fill each make the touched way the most recently used way of its set. Ways that were more recent than it each move back one place. Right after reset, way 0 counts as the most recent way and the highest-numbered way as the least recent.
- R9: A lookup presented in the same cycle as a fill strobe is dropped. It gives no response, and it leaves the recency order unchanged.
- R10: The low log2(SETS) address bits select the set and the remaining upper bits form the tag, so the same tag under a different set index misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | ADDR_W | Lookup address |
| lk_kind | input | 1 | Requested kind (0 instruction, 1 context) |
| fill_valid | input | 1 | Fill strobe, one cycle |
| fill_addr | input | ADDR_W | Fill address |
| fill_kind | input | 1 | Kind of the new line |
| fill_data | input | DATA_W | Data of the new line |
| fill_evict_kind | input | 1 | Kind that should give up a line |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_data | output | DATA_W | Hit data, zero on a miss |
| fill_done | output | 1 | Fill completed last edge |
| fill_way | output | log2(WAYS) | Way that was written |

## Verification
The bench targets these corner cases:
- **Kind mismatch on an equal tag.** A design that ignored the kind bit would return the other kind's data as a hit.
- **Full set, evict kind present.** A victim chooser that ignored the kind filter would evict the globally oldest line, which can belong to the protected kind.
- **Full set, evict kind absent.** This exercises the fallback path; a design without it would report a way of the wrong rank.
- **Empty ways.** A design that ranked empty ways by age would skip the lowest empty way.
- **Lookup in the same cycle as a fill.** A design that served both would raise `rsp_valid` or disturb the ages, which shows up in later victim numbers.
- **Same tag in another set.** This catches a wrong split between index and tag bits.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic {
    KIND_INSTR = 1'b0,
    KIND_CTX   = 1'b1
  } kind_e;
endpackage

// File: rtl/tsc_match.sv
module tsc_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0]            way_kind,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]           req_tag,
  input  tsc_pkg::kind_e             req_kind,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = way_valid[w] && (way_tag[w] == req_tag) &&
                      (tsc_pkg::kind_e'(way_kind[w]) == req_kind);
  end

  assign hit = |match;

  // lowest-numbered matching way wins
  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/tsc_victim.sv
module tsc_victim #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0]            way_kind,
  input  logic [WAYS-1:0][WAY_W-1:0] way_age,
  input  tsc_pkg::kind_e             evict_kind,
  output logic [WAY_W-1:0]           victim
);
  logic [WAYS-1:0] eligible;
  logic            inv_found, typed_found;
  logic [WAY_W-1:0] inv_way, typed_way, any_way;
  logic [WAY_W-1:0] typed_age, any_age;

  for (genvar w = 0; w < WAYS; w++) begin : g_elig
    assign eligible[w] = (tsc_pkg::kind_e'(way_kind[w]) == evict_kind);
  end

  always_comb begin
    inv_found = 1'b0;
    inv_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_valid[w]) begin
        inv_found = 1'b1;
        inv_way   = WAY_W'(w);
      end
    end
  end

  always_comb begin
    typed_found = 1'b0;
    typed_way   = '0;
    typed_age   = '0;
    any_way     = '0;
    any_age     = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_age[w] >= any_age) begin
        any_age = way_age[w];
        any_way = WAY_W'(w);
      end
      if (eligible[w] && (!typed_found || way_age[w] > typed_age)) begin
        typed_found = 1'b1;
        typed_age   = way_age[w];
        typed_way   = WAY_W'(w);
      end
    end
  end

  assign victim = inv_found   ? inv_way   :
                  typed_found ? typed_way : any_way;
endmodule

// File: rtl/tsc_recency.sv
module tsc_recency #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [IDX_W-1:0]           rd_set,
  input  logic                       touch_en,
  input  logic [WAY_W-1:0]           touch_way,
  output logic [WAYS-1:0][WAY_W-1:0] rd_age
);
  // age 0 = most recent, WAYS-1 = least recent
  logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
  logic [WAYS-1:0][WAY_W-1:0] age_nxt;
  logic [WAY_W-1:0]           touched_age;

  assign rd_age      = age_q[rd_set];
  assign touched_age = rd_age[touch_way];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == touch_way)       age_nxt[w] = '0;
      else if (rd_age[w] < touched_age) age_nxt[w] = rd_age[w] + 1'b1;
      else                              age_nxt[w] = rd_age[w];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      age_q[rd_set] <= age_nxt;
    end
  end
endmodule

// File: rtl/typed_shared_cache.sv
module typed_shared_cache #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_kind,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_kind,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fill_evict_kind,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fill_done,
  output logic [WAY_W-1:0]  fill_way
);
  import tsc_pkg::*;

  logic [WAYS-1:0][TAG_W-1:0]  tag_mem  [SETS];
  logic [WAYS-1:0][DATA_W-1:0] data_mem [SETS];
  logic [WAYS-1:0]             valid_q  [SETS];
  logic [WAYS-1:0]             kind_q   [SETS];

  logic [IDX_W-1:0] lk_idx, fill_idx, rd_set;
  logic [TAG_W-1:0] lk_tag, fill_tag;
  logic             lk_accept, hit;
  logic [WAY_W-1:0] hit_way, vic_way, touch_way;
  logic             touch_en;
  logic [WAYS-1:0][WAY_W-1:0] set_age;

  assign lk_idx    = lk_addr[IDX_W-1:0];
  assign lk_tag    = lk_addr[ADDR_W-1:IDX_W];
  assign fill_idx  = fill_addr[IDX_W-1:0];
  assign fill_tag  = fill_addr[ADDR_W-1:IDX_W];
  assign lk_accept = lk_valid && !fill_valid;
  assign rd_set    = fill_valid ? fill_idx : lk_idx;

  tsc_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .way_valid (valid_q[lk_idx]),
    .way_kind  (kind_q[lk_idx]),
    .way_tag   (tag_mem[lk_idx]),
    .req_tag   (lk_tag),
    .req_kind  (kind_e'(lk_kind)),
    .hit       (hit),
    .hit_way   (hit_way)
  );

  tsc_victim #(.WAYS(WAYS)) u_victim (
    .way_valid  (valid_q[fill_idx]),
    .way_kind   (kind_q[fill_idx]),
    .way_age    (set_age),
    .evict_kind (kind_e'(fill_evict_kind)),
    .victim     (vic_way)
  );

  assign touch_en  = fill_valid || (lk_accept && hit);
  assign touch_way = fill_valid ? vic_way : hit_way;

  tsc_recency #(.SETS(SETS), .WAYS(WAYS)) u_recency (
    .clk       (clk),
    .rst       (rst),
    .rd_set    (rd_set),
    .touch_en  (touch_en),
    .touch_way (touch_way),
    .rd_age    (set_age)
  );

  // tag and data arrays: no reset, write-only on fill
  always_ff @(posedge clk) begin
    if (fill_valid) begin
      tag_mem[fill_idx][vic_way]  <= fill_tag;
      data_mem[fill_idx][vic_way] <= fill_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        kind_q[s]  <= '0;
      end
    end else if (fill_valid) begin
      valid_q[fill_idx][vic_way] <= 1'b1;
      kind_q[fill_idx][vic_way]  <= fill_kind;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
      fill_done <= 1'b0;
      fill_way  <= '0;
    end else begin
      rsp_valid <= lk_accept;
      rsp_hit   <= lk_accept && hit;
      rsp_data  <= (lk_accept && hit) ? data_mem[lk_idx][hit_way] : '0;
      fill_done <= fill_valid;
      if (fill_valid) fill_way <= vic_way;
    end
  end
endmodule

// File: rtl/tsc_cache_checker.sv
module tsc_cache_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WAY_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_kind,
  input logic              fill_valid,
  input logic [ADDR_W-1:0] fill_addr,
  input logic              fill_kind,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [DATA_W-1:0] rsp_data,
  input logic              fill_done,
  input logic [WAY_W-1:0]  fill_way
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !fill_done));

  assert_lookup_answered_R2: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !fill_valid) |=> rsp_valid);

  assert_hit_implies_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);

  assert_miss_data_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_data == '0));

  assert_fill_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> fill_done);

  assert_no_spurious_done_R4: assert property (@(posedge clk) disable iff (rst)
    !fill_valid |=> !fill_done);

  assert_fill_then_hit_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(fill_valid, 2) && $past(lk_valid) && !$past(fill_valid) &&
     $past(lk_addr) == $past(fill_addr, 2) &&
     $past(lk_kind) == $past(fill_kind, 2)) |-> rsp_hit);

  assert_fill_drops_lookup_R9: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> !rsp_valid);

  assert_way_stable_R4: assert property (@(posedge clk) disable iff (rst)
    !fill_done |-> $stable(fill_way));
endmodule

bind typed_shared_cache tsc_cache_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAY_W(WAY_W)
) u_checker (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .lk_kind(lk_kind), .fill_valid(fill_valid), .fill_addr(fill_addr),
  .fill_kind(fill_kind), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_data(rsp_data), .fill_done(fill_done), .fill_way(fill_way)
);

// File: tb/test_typed_shared_cache.sv
module test_typed_shared_cache;
  import tsc_pkg::*;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int SETS   = 16;
  localparam int WAYS   = 4;
  localparam int IDX_W  = 4;
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int WAY_W  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 1'b0, lk_kind = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0, fill_addr = '0;
  logic fill_valid = 1'b0, fill_kind = 1'b0, fill_evict_kind = 1'b0;
  logic [DATA_W-1:0] fill_data = '0;
  logic rsp_valid, rsp_hit, fill_done;
  logic [DATA_W-1:0] rsp_data;
  logic [WAY_W-1:0] fill_way;

  always #4 clk = ~clk;

  typed_shared_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .WAYS(WAYS))
  i_typed_shared_cache (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_kind(lk_kind),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_kind(fill_kind),
    .fill_data(fill_data), .fill_evict_kind(fill_evict_kind),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .fill_done(fill_done), .fill_way(fill_way)
  );

  // reference model
  bit               m_valid [SETS][WAYS];
  bit               m_kind  [SETS][WAYS];
  logic [TAG_W-1:0] m_tag   [SETS][WAYS];
  logic [DATA_W-1:0] m_data [SETS][WAYS];
  int               m_age   [SETS][WAYS];

  int checks = 0;
  int errors = 0;

  function automatic void check(bit ok, string req, string what,
                                logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  function automatic void m_reset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_valid[s][w] = 0; m_kind[s][w] = 0; m_age[s][w] = w;
        m_tag[s][w] = '0; m_data[s][w] = '0;
      end
  endfunction

  function automatic int m_find(int s, logic [TAG_W-1:0] t, bit k);
    for (int w = 0; w < WAYS; w++)
      if (m_valid[s][w] && m_tag[s][w] == t && m_kind[s][w] == k) return w;
    return -1;
  endfunction

  function automatic int m_victim(int s, bit ek);
    int best = -1;
    for (int w = 0; w < WAYS; w++) if (!m_valid[s][w]) return w;
    for (int w = 0; w < WAYS; w++)
      if (m_kind[s][w] == ek && (best < 0 || m_age[s][w] > m_age[s][best])) best = w;
    if (best >= 0) return best;
    for (int w = 0; w < WAYS; w++)
      if (m_age[s][w] == WAYS - 1) return w;
    return 0;
  endfunction

  function automatic void m_touch(int s, int tw);
    int old = m_age[s][tw];
    for (int w = 0; w < WAYS; w++)
      if (w != tw && m_age[s][w] < old) m_age[s][w]++;
    m_age[s][tw] = 0;
  endfunction

  function automatic logic [ADDR_W-1:0] mk(int t, int s);
    return {TAG_W'(t), IDX_W'(s)};
  endfunction

  task automatic do_lookup(logic [ADDR_W-1:0] a, bit k, string req);
    int s = int'(a[IDX_W-1:0]);
    int w;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_kind = k;
    w = m_find(s, a[ADDR_W-1:IDX_W], k);
    @(posedge clk); #1;
    lk_valid = 1'b0;
    check(rsp_valid == 1'b1, req, "rsp_valid", 32'(rsp_valid), 1);
    check(rsp_hit == (w >= 0), req, "rsp_hit", 32'(rsp_hit), 32'(w >= 0));
    check(rsp_data == ((w >= 0) ? m_data[s][w] : '0), req, "rsp_data",
          rsp_data, (w >= 0) ? m_data[s][w] : '0);
    if (w >= 0) m_touch(s, w);
  endtask

  task automatic do_fill(logic [ADDR_W-1:0] a, bit k, logic [DATA_W-1:0] d,
                         bit ek, bit with_lookup, string req);
    int s = int'(a[IDX_W-1:0]);
    int v;
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = a; fill_kind = k; fill_data = d;
    fill_evict_kind = ek;
    if (with_lookup) begin
      lk_valid = 1'b1; lk_addr = mk(int'($urandom_range(5)), int'($urandom_range(15)));
      lk_kind = 1'($urandom_range(1));
    end
    v = m_victim(s, ek);
    @(posedge clk); #1;
    fill_valid = 1'b0; lk_valid = 1'b0;
    check(fill_done == 1'b1, req, "fill_done", 32'(fill_done), 1);
    check(int'(fill_way) == v, req, "fill_way", 32'(fill_way), 32'(v));
    if (with_lookup)
      check(rsp_valid == 1'b0, "R9", "rsp_valid on fill cycle", 32'(rsp_valid), 0);
    m_valid[s][v] = 1; m_kind[s][v] = k;
    m_tag[s][v] = a[ADDR_W-1:IDX_W]; m_data[s][v] = d;
    m_touch(s, v);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd1234);
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    check(rsp_valid == 0, "R1", "rsp_valid after reset", 32'(rsp_valid), 0);
    check(fill_done == 0, "R1", "fill_done after reset", 32'(fill_done), 0);
    do_lookup(mk(0, 0), KIND_INSTR, "R1");
    do_lookup(mk(3, 9), KIND_CTX, "R1");

    // set 3: empty ways filled in order
    for (int t = 1; t <= 4; t++)
      do_fill(mk(t, 3), KIND_INSTR, 32'hA000 + t, KIND_CTX, 0, "R5");
    do_lookup(mk(2, 3), KIND_CTX, "R3");
    do_lookup(mk(2, 3), KIND_INSTR, "R2");
    do_lookup(mk(2, 4), KIND_INSTR, "R10");
    do_lookup(mk(1, 3), KIND_INSTR, "R8");
    do_fill(mk(9, 3), KIND_CTX, 32'hC009, KIND_INSTR, 0, "R6");
    do_lookup(mk(9, 3), KIND_CTX, "R4");
    do_fill(mk(10, 3), KIND_CTX, 32'hC00A, KIND_CTX, 0, "R6");
    // set 5: all instruction, evict context falls back
    for (int t = 1; t <= 4; t++)
      do_fill(mk(t, 5), KIND_INSTR, 32'hB000 + t, KIND_INSTR, 0, "R5");
    do_lookup(mk(1, 5), KIND_INSTR, "R8");
    do_fill(mk(7, 5), KIND_CTX, 32'hB007, KIND_CTX, 0, "R7");
    // lookup dropped during fill
    do_fill(mk(3, 7), KIND_CTX, 32'hD003, KIND_INSTR, 1, "R9");
    do_fill(mk(4, 3), KIND_INSTR, 32'hD004, KIND_INSTR, 0, "R9");

    for (int i = 0; i < 3000; i++) begin
      int op = int'($urandom_range(99));
      logic [ADDR_W-1:0] a = mk(int'($urandom_range(5)), int'($urandom_range(15)));
      bit k = 1'($urandom_range(1));
      if (op < 60) do_lookup(a, k, "R2");
      else if (op < 95) do_fill(a, k, $urandom, 1'($urandom_range(1)), 0, "R6");
      else do_fill(a, k, $urandom, 1'($urandom_range(1)), 1, "R9");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule